// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies a 51-bit unsigned multiplicand by a 48-bit unsigned multiplier over many clock cycles and returns the full 99-bit product. Each cycle consumes one bit of the multiplier. The operand registers are written through a load strobe while the block is idle. A start pulse then launches the operation. The block reports that it is working, and after the last step it raises a completion flag and holds the product until the next start.

The multiplicand never moves during an operation. On every step the product register shifts right by one place. When the current multiplier bit is one, the multiplicand is added into the upper part of the product register. The adder therefore only needs to be as wide as the multiplicand, and its carry becomes the new top bit of the product. The multiplier register shifts right on every step, so its low bit always presents the next bit. The multiplier value is used up once the operation ends.

Top module: `shift_add_mul`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next state has `busy` low, `done` low and `product` equal to zero.
- R2: A `load` that arrives while `busy` is high has no effect on the operands, so the product of the running operation is unchanged.
- R3: A `start` accepted while idle clears `product` to zero, drives `busy` high and `done` low from the next edge onward.
- R4: An accepted operation keeps `busy` high for exactly 48 cycles. `done` rises on the same edge where `busy` falls.
- R5: When `done` rises, `product` equals the unsigned product of the loaded multiplicand and multiplier. A step whose multiplier bit is 0 only shifts the product right by one place.
- R6: While `done` is high and no new operation starts, `done` stays high and `product` is stable.
- R7: A `start` pulse that arrives while `busy` is high is ignored. The operation still lasts 48 cycles and gives the same product.
- R8: `busy` and `done` are never high together.
- R9: If `load` and `start` are both high in an idle cycle, the operands are loaded and the start is ignored, so `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| load | input | 1 | Write `a_in` and `b_in` into the operand registers while idle |
| a_in | input | 51 | Multiplicand value |
| b_in | input | 48 | Multiplier value |
| start | input | 1 | Launch an operation while idle |
| busy | output | 1 | High while steps are being performed |
| done | output | 1 | High from completion until the next start or reset |
| product | output | 99 | Product register |

## Verification
The bound checker tests several rules on every cycle: `busy` and `done` never overlap, and an accepted start clears the product. It also checks that the step counter falls by one per step and cannot be restarted by a stray start. In addition, it checks that a zero multiplier bit only shifts the product, that a finished result stays frozen, and that load has priority over start. Only the bench scenarios can show that the final product is arithmetically correct for the chosen operand patterns. The same holds for a mid-run load or start leaving that result unchanged, and for the run length measured at the ports being 48 cycles.

// File: rtl/smul_pkg.sv
package smul_pkg;
  localparam int unsigned MCAND_W_DEF = 51;
  localparam int unsigned MPLR_W_DEF  = 48;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mul_state_e;
endpackage

// File: rtl/smul_ctrl.sv
module smul_ctrl
  import smul_pkg::*;
#(
  parameter int unsigned STEPS = MPLR_W_DEF,
  localparam int unsigned CNT_W = $clog2(STEPS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             load,
  output logic             begin_op,
  output logic             step,
  output logic             last_step,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] steps_left
);
  mul_state_e state_q;
  logic [CNT_W-1:0] cnt_q;
  logic done_q;

  assign busy      = (state_q == ST_RUN);
  assign begin_op  = start && !busy && !load;
  assign step      = busy;
  assign last_step = step && (cnt_q == CNT_W'(1));
  assign done      = done_q;
  assign steps_left = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      if (begin_op) begin
        state_q <= ST_RUN;
        cnt_q   <= CNT_W'(STEPS);
        done_q  <= 1'b0;
      end else if (step) begin
        cnt_q <= cnt_q - CNT_W'(1);
        if (last_step) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/smul_operands.sv
module smul_operands #(
  parameter int unsigned A_W = 51,
  parameter int unsigned B_W = 48
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_en,
  input  logic           step,
  input  logic [A_W-1:0] a_in,
  input  logic [B_W-1:0] b_in,
  output logic [A_W-1:0] mcand,
  output logic           step_bit
);
  logic [A_W-1:0] a_q;
  logic [B_W-1:0] b_q;

  assign mcand    = a_q;
  assign step_bit = b_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else if (load_en) begin
      a_q <= a_in;
      b_q <= b_in;
    end else if (step) begin
      b_q <= b_q >> 1;
    end
  end
endmodule

// File: rtl/smul_accum.sv
module smul_accum #(
  parameter int unsigned A_W = 51,
  parameter int unsigned B_W = 48,
  localparam int unsigned P_W = A_W + B_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear,
  input  logic           step,
  input  logic           step_bit,
  input  logic [A_W-1:0] mcand,
  output logic [P_W-1:0] prod
);
  function automatic logic [P_W-1:0] next_partial(
    input logic [P_W-1:0] p,
    input logic [A_W-1:0] a,
    input logic           bit_i
  );
    logic [A_W:0] sum;
    sum = {1'b0, p[P_W-1:B_W]} + {1'b0, (a & {A_W{bit_i}})};
    return {sum, p[B_W-1:1]};
  endfunction

  logic [P_W-1:0] p_q;
  assign prod = p_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_q <= '0;
    end else if (clear) begin
      p_q <= '0;
    end else if (step) begin
      p_q <= next_partial(p_q, mcand, step_bit);
    end
  end
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul
  import smul_pkg::*;
#(
  parameter int unsigned A_W = MCAND_W_DEF,
  parameter int unsigned B_W = MPLR_W_DEF,
  localparam int unsigned P_W = A_W + B_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [A_W-1:0] a_in,
  input  logic [B_W-1:0] b_in,
  input  logic           start,
  output logic           busy,
  output logic           done,
  output logic [P_W-1:0] product
);
  localparam int unsigned CNT_W = $clog2(B_W + 1);

  logic begin_op, step, last_step, step_bit, load_en;
  logic [CNT_W-1:0] steps_left;
  logic [A_W-1:0] mcand;

  assign load_en = load && !busy;

  smul_ctrl #(.STEPS(B_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start), .load(load),
    .begin_op(begin_op), .step(step), .last_step(last_step),
    .busy(busy), .done(done), .steps_left(steps_left)
  );

  smul_operands #(.A_W(A_W), .B_W(B_W)) opnd_i (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .step(step),
    .a_in(a_in), .b_in(b_in), .mcand(mcand), .step_bit(step_bit)
  );

  smul_accum #(.A_W(A_W), .B_W(B_W)) acc_i (
    .clk(clk), .rst_n(rst_n), .clear(begin_op), .step(step),
    .step_bit(step_bit), .mcand(mcand), .prod(product)
  );
endmodule

// File: rtl/smul_checker.sv
module smul_checker #(
  parameter int unsigned P_W   = 99,
  parameter int unsigned CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load,
  input logic             busy,
  input logic             done,
  input logic             begin_op,
  input logic             step,
  input logic             last_step,
  input logic             step_bit,
  input logic [CNT_W-1:0] steps_left,
  input logic [P_W-1:0]   product
);
  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |=> (!busy && !done && product == '0));

  assert_start_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    begin_op |=> (busy && !done && product == '0));

  // R4 and R7: a start during a run does not reload the counter
  assert_count_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !last_step) |=> (busy && steps_left == $past(steps_left) - CNT_W'(1)));

  assert_finish_R4: assert property (@(posedge clk) disable iff (!rst_n)
    last_step |=> (!busy && done));

  assert_zero_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !step_bit) |=> (product == ($past(product) >> 1)));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !begin_op) |=> (done && $stable(product)));

  assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  assert_load_priority_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && load) |=> !busy);
endmodule

bind shift_add_mul smul_checker #(.P_W(P_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .load(load), .busy(busy), .done(done),
  .begin_op(begin_op), .step(step), .last_step(last_step),
  .step_bit(step_bit), .steps_left(steps_left), .product(product)
);

// File: tb/shift_add_mul_tb_top.sv
module shift_add_mul_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 51;
  localparam int BW = 48;
  localparam int PW = AW + BW;

  typedef struct {
    logic [PW-1:0] prod;
    string         tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] a_in = '0;
  logic [BW-1:0] b_in = '0;
  logic busy, done;
  logic [PW-1:0] product;

  int checks = 0;
  int errors = 0;
  exp_t exp_q[$];
  logic [PW-1:0] last_exp = '0;
  int run_len = 0;
  logic prev_busy = 1'b0;
  logic prev_done = 1'b0;
  logic finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shift_add_mul dut_i (
    .clk(clk), .rst_n(rst_n), .load(load), .a_in(a_in), .b_in(b_in),
    .start(start), .busy(busy), .done(done), .product(product)
  );

  function automatic logic [PW-1:0] ref_mul(logic [AW-1:0] a, logic [BW-1:0] b);
    return PW'(a) * PW'(b);
  endfunction

  task automatic check(bit ok, string req, logic [PW-1:0] act, logic [PW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push_exp(logic [AW-1:0] a, logic [BW-1:0] b, string tag);
    exp_t e;
    e.prod = ref_mul(a, b);
    e.tag  = tag;
    exp_q.push_back(e);
    last_exp = e.prod;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic run_op(logic [AW-1:0] a, logic [BW-1:0] b, string tag);
    @(negedge clk);
    load = 1'b1; a_in = a; b_in = b;
    @(negedge clk);
    load = 1'b0; start = 1'b1;
    push_exp(a, b, tag);
    @(negedge clk);
    start = 1'b0;
    check(busy && !done && product == '0, "R3", {busy, done, product[PW-3:0]}, {1'b1, 1'b0, 97'd0});
    wait_idle();
  endtask

  // Monitor: measures run length and compares results on rising done
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy && !prev_busy) run_len = 0;
      if (busy) run_len++;
      if (done && !prev_done) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R5", product, '0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(product == e.prod, {"R5 ", e.tag}, product, e.prod);
          check(run_len == BW, "R4", PW'(run_len), PW'(BW));
        end
      end
    end
    prev_busy = busy;
    prev_done = done;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && product == '0, "R1", {busy, done, product[PW-3:0]}, '0);
    rst_n = 1'b1;

    run_op('0, 48'hFFFF_FFFF_FFFF, "zero mcand");
    run_op(51'h7_FFFF_FFFF_FFFF, '0, "zero mplr");
    run_op(51'd1, 48'd1, "ones");
    run_op(51'h7_FFFF_FFFF_FFFF, 48'hFFFF_FFFF_FFFF, "all ones");
    run_op(51'h4_0000_0000_0000, 48'h8000_0000_0000, "top bits");
    run_op(51'h5_5555_5555_5555, 48'hAAAA_AAAA_AAAA, "alternating");
    for (int i = 0; i < 4; i++) begin
      logic [63:0] ra, rb;
      ra = {$urandom(), $urandom()};
      rb = {$urandom(), $urandom()};
      run_op(ra[AW-1:0], rb[BW-1:0], "random");
    end

    // R6: result holds while idle
    repeat (5) @(negedge clk);
    check(done && product == last_exp, "R6", product, last_exp);

    // R7 and R2: start and load during a run are ignored
    @(negedge clk);
    load = 1'b1; a_in = 51'h1_2345_6789_ABCD; b_in = 48'h0FED_CBA9_8765;
    @(negedge clk);
    load = 1'b0; start = 1'b1;
    push_exp(51'h1_2345_6789_ABCD, 48'h0FED_CBA9_8765, "R7 R2 disturbed");
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    start = 1'b1; load = 1'b1;
    a_in = 51'h7_0000_0000_0001; b_in = 48'hFFFF_0000_FFFF;
    @(negedge clk);
    start = 1'b0; load = 1'b0;
    check(busy, "R7", PW'(busy), PW'(1));
    wait_idle();

    // R9: load and start together loads but does not start
    @(negedge clk);
    load = 1'b1; start = 1'b1; a_in = 51'd12345; b_in = 48'd67890;
    @(negedge clk);
    load = 1'b0; start = 1'b0;
    check(!busy && done, "R9", {busy, done}, {1'b0, 1'b1});
    start = 1'b1;
    push_exp(51'd12345, 48'd67890, "R9 follow-up");
    @(negedge clk);
    start = 1'b0;
    wait_idle();

    // R1: reset in the middle of a run
    run_op(51'd3, 48'd5, "before reset");
    @(negedge clk);
    load = 1'b1; a_in = 51'd7; b_in = 48'd9;
    @(negedge clk);
    load = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(!busy && !done && product == '0, "R1", {busy, done, product[PW-3:0]}, '0);
    rst_n = 1'b1;

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R5", PW'(exp_q.size()), '0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule